// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execute stage of a small processor datapath. It combines two 32-bit operands combinationally under a two-bit operation select: add, subtract, bitwise AND or bitwise XOR. The result is returned in the same cycle. A registered status word holds four bits: negative, zero, carry and signed overflow. Later conditional logic reads that word.

Two classes of operation share the datapath. When the compare-class indicator is high, the block computes the result for its flags only. In that case the flags are always written and write-back is suppressed. The compare-class forms are compare (subtract), compare-negative (add), test (AND) and test-equivalence (XOR). When the indicator is low, the operation is an ordinary data operation. Its result is written back, and the flags change only if the set-flags request accompanies it.

An issue strobe, `op_valid`, marks a cycle that carries an operation. The block accepts one operation in every cycle and never applies back-pressure, so it has no ready output. Write-back enable is the only downstream qualifier. The flags seen at `flags` always reflect the last qualifying operation, one clock after it was issued.

Top module: `flag_alu`

## Requirements
- R1: `result` equals, in the same cycle, a+b mod 2^32 for op_sel 00, a-b mod 2^32 for 01, a AND b for 10 and a XOR b for 11, regardless of the compare-class indicator.
- R2: `wb_en` is high exactly when `op_valid` is high and `cmp_class` is low.
- R3: A high `rst` at a rising edge clears `flags` to 4'b0000 at that edge and takes priority over any update.
- R4: `flags` keeps its value across an edge where `op_valid` is low, or where a data operation (`cmp_class` low) arrives with `set_flags` low.
- R5: With `op_valid` and `cmp_class` high, `flags` is updated at the next edge whatever the value of `set_flags`.
- R6: On an update, flags bit 3 (N) becomes bit 31 of the result and bit 2 (Z) becomes 1 exactly when the result is zero.
- R7: On an update by add, flags bit 1 (C) becomes the carry out of bit 31. On an update by subtract, C becomes 1 exactly when a >= b as unsigned values, meaning no borrow occurred.
- R8: On an update by add, flags bit 0 (V) becomes 1 when a and b have the same sign and the result sign differs. On an update by subtract, V becomes 1 when the signs of a and b differ and the result sign differs from a.
- R9: On an update by AND or XOR, C and V keep their previous values while N and Z follow the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| cmp_class | input | 1 | Compute for flags only, no write-back |
| set_flags | input | 1 | Data operation also writes the flags |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| wb_en | output | 1 | Result is to be written back |
| flags | output | 4 | Registered {N, Z, C, V} |

## Verification
In a single cycle, the flag update can coincide with the gating of write-back, and a logical update can coincide with retention of C and V from an earlier arithmetic operation. The bench provokes the first by issuing compare-class operations with `set_flags` both low and high. It provokes the second by running an arithmetic operation that sets C and V, immediately followed by a flag-setting AND or XOR. A behavioural reference model tracks the flag word through every clock, and its values are compared against `result`, `wb_en` and `flags` each cycle. The inputs also include a reset asserted together with a flag-setting operation, and the reference model requires that the reset wins.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // Subtraction as a + ~b + 1; carry out then means "no borrow".
  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_xor,
  output logic [W-1:0] y
);
  always_comb begin
    if (use_xor) y = a ^ b;
    else         y = a & b;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic       keep_cv,
  input  alu_flags_t nxt,
  output alu_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd) begin
      q.n <= nxt.n;
      q.z <= nxt.z;
      if (!keep_cv) begin
        q.c <= nxt.c;
        q.v <= nxt.v;
      end
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [1:0]   op_sel,
  input  logic         cmp_class,
  input  logic         set_flags,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         wb_en,
  output logic [3:0]   flags
);
  alu_op_e      op;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         arith_c;
  logic         arith_v;
  logic         is_logic;
  logic         upd;
  alu_flags_t   nxt;
  alu_flags_t   cur;

  assign op       = alu_op_e'(op_sel);
  assign is_logic = op_sel[1];

  alu_arith #(.W(W)) u_arith (
    .a     (opa),
    .b     (opb),
    .sub   (op == OP_SUB),
    .sum   (arith_y),
    .carry (arith_c),
    .ovf   (arith_v)
  );

  alu_logic #(.W(W)) u_logic (
    .a       (opa),
    .b       (opb),
    .use_xor (op == OP_XOR),
    .y       (logic_y)
  );

  assign result = is_logic ? logic_y : arith_y;
  assign wb_en  = op_valid & ~cmp_class;
  assign upd    = op_valid & (cmp_class | set_flags);

  always_comb begin
    nxt.n = result[W-1];
    nxt.z = (result == '0);
    nxt.c = arith_c;
    nxt.v = arith_v;
  end

  alu_flag_reg u_flags (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .keep_cv (is_logic),
    .nxt     (nxt),
    .q       (cur)
  );

  assign flags = cur;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [1:0]   op_sel,
  input logic         cmp_class,
  input logic         set_flags,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] result,
  input logic         wb_en,
  input logic [3:0]   flags
);
  logic upd_seen;
  assign upd_seen = op_valid && (cmp_class || set_flags);

  // R3
  p_reset_clears_r3: assert property (@(posedge clk) rst |=> flags == 4'b0000);

  // R2
  p_wb_gating_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_class) |-> !wb_en);

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd_seen |=> $stable(flags));

  // R5 and R6
  p_cmp_nz_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_class) |=>
      (flags[3] == $past(result[W-1])) && (flags[2] == ($past(result) == '0)));

  // R6
  p_nz_follow_r6: assert property (@(posedge clk) disable iff (rst)
    upd_seen |=> flags[3] == $past(result[W-1]));

  // R7
  p_sub_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_seen && op_sel == 2'b01) |=> flags[1] == $past(opa >= opb));

  // R9
  p_logic_keep_cv_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_seen && op_sel[1]) |=> flags[1:0] == $past(flags[1:0]));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .cmp_class (cmp_class),
  .set_flags (set_flags),
  .opa       (opa),
  .opb       (opb),
  .result    (result),
  .wb_en     (wb_en),
  .flags     (flags)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic        cmp_class;
  logic        set_flags;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [31:0] result;
  logic        wb_en;
  logic [3:0]  flags;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  logic [3:0] mflags = 4'b0000;

  always #2 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .cmp_class(cmp_class), .set_flags(set_flags), .opa(opa), .opb(opb),
    .result(result), .wb_en(wb_en), .flags(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation: drive at negedge, check combinational outputs,
  // advance the reference model at the edge, check the flags after it.
  task automatic step(input logic r, input logic v, input logic [1:0] sel,
                      input logic cc, input logic sf,
                      input logic [31:0] a, input logic [31:0] b);
    logic [32:0] wide;
    logic [31:0] y;
    logic        c, ov, up;
    @(negedge clk);
    rst = r; op_valid = v; op_sel = sel; cmp_class = cc; set_flags = sf;
    opa = a; opb = b;
    c = mflags[1]; ov = mflags[0];
    case (sel)
      2'b00: begin
        wide = {1'b0, a} + {1'b0, b}; y = wide[31:0]; c = wide[32];
        ov = (a[31] == b[31]) && (y[31] != a[31]);
      end
      2'b01: begin
        y = a - b; c = (a >= b);
        ov = (a[31] != b[31]) && (y[31] != a[31]);
      end
      2'b10: y = a & b;
      default: y = a ^ b;
    endcase
    #1;
    check("R1", result, y);
    check("R2", {31'd0, wb_en}, {31'd0, v && !cc});
    up = v && (cc || sf);
    @(posedge clk);
    if (r) mflags = 4'b0000;
    else if (up) mflags = {y[31], (y == 32'd0), c, ov};
    #1;
    if (r)             check("R3", {28'd0, flags}, {28'd0, mflags});
    else if (!up)      check("R4", {28'd0, flags}, {28'd0, mflags});
    else if (cc)       check("R5", {28'd0, flags}, {28'd0, mflags});
    else if (sel[1])   check("R9", {28'd0, flags}, {28'd0, mflags});
    else if (sel == 0) check("R7 R8 add", {28'd0, flags}, {28'd0, mflags});
    else               check("R7 R8 sub", {28'd0, flags}, {28'd0, mflags});
    check("R6", {30'd0, flags[3:2]}, {30'd0, mflags[3:2]});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_sel = 2'b00; cmp_class = 1'b0;
    set_flags = 1'b0; opa = '0; opb = '0;
    // R3: reset with a flag-setting op present
    step(1, 1, 2'b01, 1, 1, 32'h0, 32'h1);
    step(1, 0, 2'b00, 0, 0, 32'h5, 32'h5);
    // R7 R8 add: carry and zero
    step(0, 1, 2'b00, 0, 1, 32'hFFFF_FFFF, 32'h1);
    // R8 add: signed overflow
    step(0, 1, 2'b00, 1, 0, 32'h7FFF_FFFF, 32'h1);
    // R9: logic keeps C and V from the previous arithmetic op
    step(0, 1, 2'b10, 0, 1, 32'hF0F0_0000, 32'h0F0F_0000);
    step(0, 1, 2'b11, 1, 0, 32'h8000_0001, 32'h0000_0001);
    // R7: subtract equal gives Z and C
    step(0, 1, 2'b01, 1, 0, 32'h1234, 32'h1234);
    // R7: borrow
    step(0, 1, 2'b01, 1, 1, 32'h1, 32'h2);
    // R8 sub: overflow
    step(0, 1, 2'b01, 0, 1, 32'h8000_0000, 32'h1);
    // R4: data op without set_flags, and idle with a compare presented
    step(0, 1, 2'b00, 0, 0, 32'h0, 32'h0);
    step(0, 0, 2'b01, 1, 1, 32'h3, 32'h3);
    // R5: compare-class test with set_flags low
    step(0, 1, 2'b10, 1, 0, 32'hFFFF_0000, 32'h0000_FFFF);
    // R3: reset during operation
    step(1, 1, 2'b00, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 50) == 0, ($urandom % 5) != 0, 2'($urandom),
           1'($urandom), 1'($urandom), $urandom,
           (($urandom % 6) == 0) ? 32'h8000_0000 : $urandom);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule